// File: doc/BRIEF.md
# Address-Checked Parity RAM

This block wraps an 8 KB on-chip word memory and adds one parity bit to every stored word. The parity bit covers the write data and also the word address (bits 31:2), so a read that lands on a different location than the one written shows a mismatch. It is reached through a simple request port. A request carries a valid strobe, a write select, a byte address and write data. A read returns data one cycle later, together with a single-cycle error pulse when the recomputed parity disagrees with the stored bit.

The memory answers at its home window `0x2000_0000`–`0x2000_1FFF`. While `remap_en` is high it also answers at an alias window based at zero. Because address bit 29 differs between the two windows, code written at the home window and read through the alias fails the check unless software sets a bypass bit. That bit removes address bit 29 from parity on both store and check. A control word at byte offset `0x18` from the control base holds the bypass bit, a sticky error flag and three lock bits. A test input can invert the parity bit being stored, so that the detection path can be exercised.

Top module: `addr_parity_ram`

## Requirements
- R1: After reset, a read of the control word at `CFG_BASE + 0x18` returns 0 and neither `rsp_valid` nor `par_err` is asserted.
- R2: A read request returns `rsp_valid` high with its data exactly one cycle after the request. A write produces no `rsp_valid`.
- R3: A write stores the even parity of the 32 data bits XOR the parity of address bits 31:2. A read recomputes it from the returned data and the read address. On a mismatch, `par_err` is high for exactly the one cycle in which `rsp_valid` is high.
- R4: With the bypass bit at 0, a word written at `0x2000_xxxx` and read at the same offset through the zero-based alias reports `par_err`.
- R5: With the bypass bit at 1, address bit 29 is forced to 0 in the parity on both store and check. Alias reads of words stored with bypass on check clean. A word stored with bypass off, where bit 29 was 1, fails when read with bypass on.
- R6: Control bit 4 (bypass) is set by writing 1. Writing 0 leaves it unchanged, and only reset clears it.
- R7: Control bit 8 (error flag) is set by hardware in the cycle after a `par_err` pulse. Writing 1 to it clears it, and writing 0 has no effect.
- R8: When a `par_err` pulse and a write of 1 to bit 8 fall in the same cycle, the flag ends up 1.
- R9: Control bits 2:0 (locks) are each set by writing 1. Writes of 0 do not clear them, and only reset does.
- R10: Control bits 31:9, 7:5 and 3 read as 0 whatever is written to them.
- R11: A write made with `inj_flip` high stores the inverted parity bit, and the next read of that word reports `par_err`.
- R12: An address outside the home window, outside the alias window (or in it with `remap_en` low) and off the control word ignores writes. A read of such an address returns 0 with `rsp_valid` high and no `par_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| remap_en | input | 1 | Enables the zero-based alias window |
| inj_flip | input | 1 | Inverts the parity bit stored by the current write |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| par_err | output | 1 | Single-cycle parity mismatch pulse |

## Verification
Each request is driven on a falling edge and captured on the next rising edge. Read data, `rsp_valid` and `par_err` are therefore due in the cycle after that edge, and the bench samples them on the following falling edge. One more falling edge later the bench confirms that the pulse has gone. The sticky flag changes at the rising edge that closes the pulse cycle. The bench reads it back through the control word no earlier than the next request. For the priority case, the clear request is placed in the same cycle as the pulse.

// File: rtl/apr_pkg.sv
package apr_pkg;
  localparam int WORD_W   = 32;
  localparam int ALIAS_BIT = 29;

  // control word field positions
  localparam int FLAG_POS   = 8;
  localparam int BYPASS_POS = 4;
  localparam int LOCK_N     = 3;

  // parity of the word address, bit ALIAS_BIT optionally masked
  function automatic logic addr_par(input logic [WORD_W-1:0] a, input logic byp);
    logic [WORD_W-1:0] m;
    m = a;
    if (byp) m[ALIAS_BIT] = 1'b0;
    return ^m[WORD_W-1:2];
  endfunction

  function automatic logic data_par(input logic [WORD_W-1:0] d);
    return ^d;
  endfunction

  function automatic logic word_par(input logic [WORD_W-1:0] d,
                                    input logic [WORD_W-1:0] a,
                                    input logic byp);
    return data_par(d) ^ addr_par(a, byp);
  endfunction
endpackage

// File: rtl/apr_addr_decode.sv
module apr_addr_decode #(
  parameter int          WIN_LSB  = 13,
  parameter logic [31:0] MEM_BASE = 32'h2000_0000,
  parameter logic [31:0] CFG_ADDR = 32'h4001_0018
) (
  input  logic [31:0] addr,
  input  logic        remap_en,
  output logic        hit_mem,
  output logic        hit_cfg
);
  logic home_hit, alias_hit;
  always_comb begin
    home_hit  = (addr[31:WIN_LSB] == MEM_BASE[31:WIN_LSB]);
    alias_hit = remap_en && (addr[31:WIN_LSB] == '0);
    hit_mem   = home_hit || alias_hit;
    hit_cfg   = (addr == CFG_ADDR);
  end
endmodule

// File: rtl/apr_mem_array.sv
module apr_mem_array #(
  parameter int WORDS = 2048,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          wpar,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata,
  output logic          rpar
);
  logic [DW:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= {wpar, wdata};
    if (re) {rpar, rdata} <= store[ridx];
  end
endmodule

// File: rtl/apr_cfg_reg.sv
module apr_cfg_reg
  import apr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_flag,
  input  logic              wr_bypass,
  input  logic [LOCK_N-1:0] wr_lock,
  input  logic              set_err,
  output logic              flag_q,
  output logic              bypass_q,
  output logic [LOCK_N-1:0] lock_q,
  output logic [WORD_W-1:0] cfg_word
);
  // per-bit set-only lock cells
  for (genvar i = 0; i < LOCK_N; i++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   lock_q[i] <= 1'b0;
      else if (wr_en && wr_lock[i]) lock_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bypass_q <= 1'b0;
    else if (wr_en && wr_bypass) bypass_q <= 1'b1;
  end

  // hardware set wins over software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (set_err)          flag_q <= 1'b1;
    else if (wr_en && wr_flag) flag_q <= 1'b0;
  end

  always_comb begin
    cfg_word             = '0;
    cfg_word[FLAG_POS]   = flag_q;
    cfg_word[BYPASS_POS] = bypass_q;
    cfg_word[LOCK_N-1:0] = lock_q;
  end
endmodule

// File: rtl/addr_parity_ram.sv
module addr_parity_ram
  import apr_pkg::*;
#(
  parameter int          MEM_BYTES  = 8192,
  parameter logic [31:0] MEM_BASE   = 32'h2000_0000,
  parameter logic [31:0] CFG_BASE   = 32'h4001_0000,
  parameter logic [31:0] CFG_OFFSET = 32'h0000_0018
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        remap_en,
  input  logic        inj_flip,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        par_err
);
  localparam int          WORDS    = MEM_BYTES / (WORD_W / 8);
  localparam int          IW       = $clog2(WORDS);
  localparam int          WIN_LSB  = $clog2(MEM_BYTES);
  localparam logic [31:0] CFG_ADDR = CFG_BASE + CFG_OFFSET;

  // named internal events
  logic              hit_mem, hit_cfg;
  logic              mem_wr, mem_rd, cfg_wr, any_rd;
  logic              store_par;
  logic              flag_q, bypass_q;
  logic [LOCK_N-1:0] lock_q;
  logic [WORD_W-1:0] cfg_word;
  logic [WORD_W-1:0] mem_rdata;
  logic              mem_rpar;
  logic              check_par;
  logic              mismatch;

  // response-side registers
  logic              rsp_valid_q, sel_mem_q, sel_cfg_q, byp_q;
  logic [31:0]       addr_q;
  logic [WORD_W-1:0] cfg_snap_q;

  apr_addr_decode #(
    .WIN_LSB (WIN_LSB),
    .MEM_BASE(MEM_BASE),
    .CFG_ADDR(CFG_ADDR)
  ) u_dec (
    .addr    (req_addr),
    .remap_en(remap_en),
    .hit_mem (hit_mem),
    .hit_cfg (hit_cfg)
  );

  always_comb begin
    mem_wr    = req_valid && req_write && hit_mem;
    cfg_wr    = req_valid && req_write && hit_cfg;
    any_rd    = req_valid && !req_write;
    mem_rd    = any_rd && hit_mem;
    store_par = word_par(req_wdata, req_addr, bypass_q) ^ inj_flip;
  end

  apr_mem_array #(
    .WORDS(WORDS),
    .DW   (WORD_W)
  ) u_mem (
    .clk  (clk),
    .we   (mem_wr),
    .widx (req_addr[WIN_LSB-1:2]),
    .wdata(req_wdata),
    .wpar (store_par),
    .re   (mem_rd),
    .ridx (req_addr[WIN_LSB-1:2]),
    .rdata(mem_rdata),
    .rpar (mem_rpar)
  );

  apr_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_flag  (req_wdata[FLAG_POS]),
    .wr_bypass(req_wdata[BYPASS_POS]),
    .wr_lock  (req_wdata[LOCK_N-1:0]),
    .set_err  (par_err),
    .flag_q   (flag_q),
    .bypass_q (bypass_q),
    .lock_q   (lock_q),
    .cfg_word (cfg_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      sel_mem_q   <= 1'b0;
      sel_cfg_q   <= 1'b0;
      byp_q       <= 1'b0;
      addr_q      <= '0;
      cfg_snap_q  <= '0;
    end else begin
      rsp_valid_q <= any_rd;
      sel_mem_q   <= mem_rd;
      sel_cfg_q   <= any_rd && hit_cfg;
      if (any_rd) begin
        byp_q      <= bypass_q;
        addr_q     <= req_addr;
        cfg_snap_q <= cfg_word;
      end
    end
  end

  always_comb begin
    check_par = word_par(mem_rdata, addr_q, byp_q);
    mismatch  = sel_mem_q && (check_par != mem_rpar);
    rsp_valid = rsp_valid_q;
    par_err   = rsp_valid_q && mismatch;
    if (sel_mem_q)      rsp_rdata = mem_rdata;
    else if (sel_cfg_q) rsp_rdata = cfg_snap_q;
    else                rsp_rdata = '0;
  end
endmodule

// File: rtl/apr_chk.sv
module apr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        par_err,
  input logic        flag_q,
  input logic        bypass_q,
  input logic [2:0]  lock_q,
  input logic [31:0] cfg_word
);
  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R3
  err_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> rsp_valid);

  // R7
  flag_follows_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> flag_q);

  // R6
  bypass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bypass_q) |-> bypass_q);

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & $past(lock_q)) == $past(lock_q));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[31:9] == '0) && (cfg_word[7:5] == '0) && !cfg_word[3]);
endmodule

bind addr_parity_ram apr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .rsp_valid(rsp_valid),
  .par_err  (par_err),
  .flag_q   (flag_q),
  .bypass_q (bypass_q),
  .lock_q   (lock_q),
  .cfg_word (cfg_word)
);

// File: tb/sim_addr_parity_ram.sv
module sim_addr_parity_ram;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] CFG        = 32'h4001_0018;
  localparam logic [1:0]  OP_WR = 2'd0, OP_RD = 2'd1, OP_CW = 2'd2;
  localparam int          NV = 13;

  // {op, flip, addr, data, exp_err, exp_data}
  localparam logic [99:0] VEC [NV] = '{
    {OP_CW, 1'b0, CFG,          32'h0,          1'b0, 32'h0},
    {OP_WR, 1'b0, 32'h2000_0010, 32'hA5A5_0001, 1'b0, 32'h0},
    {OP_RD, 1'b0, 32'h2000_0010, 32'h0,         1'b0, 32'hA5A5_0001}, // R3 clean
    {OP_RD, 1'b0, 32'h0000_0010, 32'h0,         1'b1, 32'hA5A5_0001}, // R4
    {OP_CW, 1'b0, CFG,          32'h10,         1'b0, 32'h0},
    {OP_WR, 1'b0, 32'h2000_0020, 32'h1234_5678, 1'b0, 32'h0},
    {OP_RD, 1'b0, 32'h0000_0020, 32'h0,         1'b0, 32'h1234_5678}, // R5
    {OP_RD, 1'b0, 32'h2000_0020, 32'h0,         1'b0, 32'h1234_5678}, // R5
    {OP_WR, 1'b1, 32'h2000_0030, 32'h0000_00FF, 1'b0, 32'h0},
    {OP_RD, 1'b0, 32'h2000_0030, 32'h0,         1'b1, 32'h0000_00FF}, // R11
    {OP_WR, 1'b0, 32'h2000_1FFC, 32'hFFFF_FFFF, 1'b0, 32'h0},
    {OP_RD, 1'b0, 32'h0000_1FFC, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R5 top word
    {OP_RD, 1'b0, 32'h2000_0010, 32'h0,         1'b1, 32'hA5A5_0001}  // R5 stored w/o bypass
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        remap_en = 1'b1, inj_flip = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid, par_err;
  logic [31:0] rsp_rdata;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_parity_ram u0 (
    .clk(clk), .rst_n(rst_n), .remap_en(remap_en), .inj_flip(inj_flip),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .par_err(par_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on a falling edge; sample the response on the next falling edge
  task automatic op(input logic wr, input logic flip, input logic [31:0] a,
                    input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; inj_flip = flip;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; inj_flip = 1'b0;
  endtask

  task automatic rd_cfg(input string req, input logic [31:0] exp);
    op(1'b0, 1'b0, CFG, 32'h0);
    check(req, rsp_rdata, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R1 par_err", {31'b0, par_err}, 32'h0);
    rst_n = 1'b1;
    rd_cfg("R1 cfg reset", 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] o;
      o = VEC[i][99:98];
      op(o != OP_RD, VEC[i][97], VEC[i][96:65], VEC[i][64:33]);
      if (o == OP_RD) begin
        check("R2 rsp_valid", {31'b0, rsp_valid}, 32'h1);
        check("R2 rdata", rsp_rdata, VEC[i][31:0]);
        check("R3/R4/R5/R11 par_err", {31'b0, par_err}, {31'b0, VEC[i][32]});
        @(negedge clk);
        check("R3 pulse width", {31'b0, par_err}, 32'h0);
      end else begin
        check("R2 no rsp on write", {31'b0, rsp_valid}, 32'h0);
      end
    end

    // flag set, bypass set
    rd_cfg("R7 flag set", 32'h110);
    op(1'b1, 1'b0, CFG, 32'h0);
    rd_cfg("R7 write 0 keeps flag", 32'h110);
    op(1'b1, 1'b0, CFG, 32'h100);
    rd_cfg("R7 w1c", 32'h010);
    rd_cfg("R6 bypass stays after write 0", 32'h010);
    op(1'b1, 1'b0, CFG, 32'h7);
    rd_cfg("R9 locks set", 32'h017);
    op(1'b1, 1'b0, CFG, 32'h0);
    rd_cfg("R9 locks sticky", 32'h017);
    op(1'b1, 1'b0, CFG, 32'hFFFF_FEE8);
    rd_cfg("R10 reserved zero", 32'h017);

    // R8: error pulse and clear in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h2000_0030;
    @(negedge clk);
    check("R8 err pulse", {31'b0, par_err}, 32'h1);
    req_write = 1'b1; req_addr = CFG; req_wdata = 32'h100;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd_cfg("R8 set wins", 32'h117);

    // R12 unmapped / alias disabled
    remap_en = 1'b0;
    op(1'b0, 1'b0, 32'h0000_0020, 32'h0);
    check("R12 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    check("R12 rdata", rsp_rdata, 32'h0);
    check("R12 par_err", {31'b0, par_err}, 32'h0);
    op(1'b1, 1'b0, 32'h3000_0020, 32'hDEAD_BEEF);
    remap_en = 1'b1;
    op(1'b0, 1'b0, 32'h0000_0020, 32'h0);
    check("R12 unmapped write ignored", rsp_rdata, 32'h1234_5678);
    check("R12 alias clean", {31'b0, par_err}, 32'h0);

    // R6/R1 reset clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_cfg("R6 reset clears cfg", 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule